// File: doc/BRIEF.md
# Decoded Event Serial Output Formatter

This block reports a decoded radio event to a host controller over a narrow serial link. When the receiver logic raises a send request, the formatter captures a ten-bit frame and sends it most significant position first. The frame is either an event frame (function bits, low-battery flag, repeat flag, slot index) or a learn-status frame (learn result, overwrite flag, slot index). A busy flag covers the whole transfer.

The link works in one of two modes, chosen with each request. In one-wire mode only the data line toggles. Each bit is a cell of three time units, and the bit value sets where the high part of the cell ends. In two-wire mode the block also drives a clock. Each bit spans two units: the data line changes as the clock rises, and the host samples it while the clock is low.

All timing comes from one prescaler. It divides the system clock into a time unit of `UNIT_CYCLES` cycles, which is 400 µs in the intended system.

Top module: `evt_serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `busy`, `data_o` and `clk_o` are all low.
- R2: An event frame carries, in send order (position 9 down to position 0), these bits: 1, func[3], func[2], func[1], func[0], low_batt, rpt, slot[1], slot[0], 0.
- R3: When `status_sel` is 1, the frame carries, in send order, these bits: 1, 0, 0, 0, 0, learn_ok, overwrite, slot[1], slot[0], 0. The `func`, `low_batt` and `rpt` inputs have no effect on it.
- R4: Every frame begins with a start bit of 1 and ends with a stop bit of 0, in both modes.
- R5: With `two_wire` = 0, each bit is a cell of 3 units of `UNIT_CYCLES` cycles. A 1 is high for unit 0 and low for units 1 and 2. A 0 is high for units 0 and 1 and low for unit 2. `clk_o` stays low throughout.
- R6: With `two_wire` = 1, each bit lasts 2 units. `clk_o` is high in unit 0 and low in unit 1. `data_o` holds the bit value for the whole bit and changes only in the cycle in which `clk_o` rises.
- R7: A request seen while idle is accepted at that clock edge. `busy` is high from the next cycle for exactly 10 × cell-units × `UNIT_CYCLES` cycles.
- R8: A request made while `busy` is high is ignored. The running frame is unchanged, and no frame follows once the running frame ends.
- R9: The mode, the frame type and all payload bits are captured when the request is accepted. Input changes during the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Send request, accepted when idle |
| status_sel | input | 1 | 1 selects the learn-status frame, 0 the event frame |
| two_wire | input | 1 | 1 selects clocked two-wire mode, 0 selects one-wire pulse-width mode |
| func | input | 4 | Function bits; func[3] is sent first |
| low_batt | input | 1 | Low-battery flag (event frame) |
| rpt | input | 1 | Repeated-transmission flag (event frame) |
| slot | input | 2 | Learned-transmitter count minus one (00 = one, 11 = four) |
| learn_ok | input | 1 | Learn result flag (status frame) |
| overwrite | input | 1 | Slot-overwritten flag (status frame) |
| data_o | output | 1 | Serial data line |
| clk_o | output | 1 | Serial clock line, used in two-wire mode only |
| busy | output | 1 | High while a frame is being sent |

## Verification
A request is accepted at a rising edge. `busy` and the first unit of the start bit appear in the cycle that follows. After that, output sample k lies in unit k / `UNIT_CYCLES`, and the bit index is that unit divided by the units per bit. The bench raises `req` at a falling edge. It then samples `data_o`, `clk_o` and `busy` at every later falling edge, counting from the first busy cycle, and compares each sample against a waveform built from the requirements. The sample taken one cell count past the end must show the idle state. The decoded bit for each cell is read in unit 1: the low-clock half in two-wire mode, and the unit that separates a 1 from a 0 in one-wire mode.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int FRAME_LEN      = 10;
  localparam int ONE_WIRE_UNITS = 3;
  localparam int TWO_WIRE_UNITS = 2;

  typedef logic [FRAME_LEN-1:0] frame_t;

  typedef enum logic {ST_IDLE, ST_SEND} ser_state_e;

  typedef struct packed {
    logic [3:0] func;
    logic       low_batt;
    logic       rpt;
    logic [1:0] slot;
    logic       learn_ok;
    logic       overwrite;
  } evt_payload_t;
endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
  parameter int UNIT_CYCLES = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evt_frame_build.sv
module evt_frame_build
  import evt_pkg::*;
(
  input  logic         status_sel,
  input  evt_payload_t pay,
  output frame_t       frame
);
  logic [3:0] mid_bits;
  logic [1:0] flag_bits;

  always_comb begin
    if (status_sel) begin
      mid_bits  = 4'b0000;
      flag_bits = {pay.learn_ok, pay.overwrite};
    end else begin
      mid_bits  = pay.func;
      flag_bits = {pay.low_batt, pay.rpt};
    end
  end

  // send order: start, four middle bits, two flags, slot, stop
  assign frame = {1'b1, mid_bits, flag_bits, pay.slot, 1'b0};
endmodule

// File: rtl/evt_serializer.sv
module evt_serializer
  import evt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   two_wire,
  input  frame_t frame_in,
  input  logic   tick,
  output logic   busy,
  output logic   data_o,
  output logic   clk_o
);
  localparam int BW = $clog2(FRAME_LEN);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_LEN - 1);
  localparam logic [1:0] ONE_LAST = 2'(ONE_WIRE_UNITS - 1);
  localparam logic [1:0] TWO_LAST = 2'(TWO_WIRE_UNITS - 1);

  ser_state_e    state_q, state_d;
  frame_t        sr_q, sr_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [1:0]    unit_q, unit_d;
  logic          two_q, two_d;
  logic [1:0]    last_unit;
  logic          cur;

  assign last_unit = two_q ? TWO_LAST : ONE_LAST;
  assign cur       = sr_q[FRAME_LEN-1];

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    bit_d   = bit_q;
    unit_d  = unit_q;
    two_d   = two_q;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_SEND;
          sr_d    = frame_in;
          bit_d   = '0;
          unit_d  = '0;
          two_d   = two_wire;
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (unit_q == last_unit) begin
            unit_d = '0;
            if (bit_q == LAST_BIT) begin
              state_d = ST_IDLE;
              sr_d    = '0;
              bit_d   = '0;
            end else begin
              bit_d = bit_q + 1'b1;
              sr_d  = {sr_q[FRAME_LEN-2:0], 1'b0};
            end
          end else begin
            unit_d = unit_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      bit_q   <= '0;
      unit_q  <= '0;
      two_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      bit_q   <= bit_d;
      unit_q  <= unit_d;
      two_q   <= two_d;
    end
  end

  assign busy = (state_q == ST_SEND);

  always_comb begin
    data_o = 1'b0;
    clk_o  = 1'b0;
    if (busy) begin
      if (two_q) begin
        data_o = cur;
        clk_o  = (unit_q == 2'd0);
      end else begin
        data_o = (unit_q == 2'd0) || ((unit_q == 2'd1) && !cur);
      end
    end
  end
endmodule

// File: rtl/evt_serial_tx.sv
module evt_serial_tx
  import evt_pkg::*;
#(
  parameter int UNIT_CYCLES = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       status_sel,
  input  logic       two_wire,
  input  logic [3:0] func,
  input  logic       low_batt,
  input  logic       rpt,
  input  logic [1:0] slot,
  input  logic       learn_ok,
  input  logic       overwrite,
  output logic       data_o,
  output logic       clk_o,
  output logic       busy
);
  evt_payload_t pay;
  frame_t       frame;
  logic         tick;

  assign pay = '{func: func, low_batt: low_batt, rpt: rpt, slot: slot,
                 learn_ok: learn_ok, overwrite: overwrite};

  evt_frame_build u_build (
    .status_sel (status_sel),
    .pay        (pay),
    .frame      (frame)
  );

  evt_tick_gen #(.UNIT_CYCLES(UNIT_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  evt_serializer u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .two_wire (two_wire),
    .frame_in (frame),
    .tick     (tick),
    .busy     (busy),
    .data_o   (data_o),
    .clk_o    (clk_o)
  );
endmodule

// File: rtl/evt_serial_tx_chk.sv
module evt_serial_tx_chk
  import evt_pkg::*;
#(
  parameter int UNIT_CYCLES = 1600
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic two_wire,
  input logic busy,
  input logic data_o,
  input logic clk_o
);
  logic        mode_q;
  logic [31:0] cnt_q;
  logic [31:0] exp_len;

  assign exp_len = 32'(FRAME_LEN * UNIT_CYCLES) *
                   (mode_q ? 32'(TWO_WIRE_UNITS) : 32'(ONE_WIRE_UNITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (req && !busy) begin
      mode_q <= two_wire;
      cnt_q  <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!data_o && !clk_o)); // R1

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> data_o); // R4

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(data_o)); // R4

  AST_ONE_WIRE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> !clk_o); // R5

  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mode_q && !$stable(data_o)) |-> $rose(clk_o)); // R6

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cnt_q == exp_len)); // R7
endmodule

bind evt_serial_tx evt_serial_tx_chk #(.UNIT_CYCLES(UNIT_CYCLES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (req),
  .two_wire (two_wire),
  .busy   (busy),
  .data_o (data_o),
  .clk_o  (clk_o)
);

// File: tb/evt_serial_tx_test.sv
module evt_serial_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 4;
  localparam int NBITS = 10;
  localparam int MAXL = NBITS * 3 * UNIT;

  logic clk = 1'b0;
  logic rst_n;
  logic req, status_sel, two_wire, low_batt, rpt, learn_ok, overwrite;
  logic [3:0] func;
  logic [1:0] slot;
  logic data_o, clk_o, busy;

  int checks = 0;
  int errors = 0;
  logic d_s [0:MAXL];
  logic c_s [0:MAXL];
  logic b_s [0:MAXL];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_serial_tx #(.UNIT_CYCLES(UNIT)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .status_sel(status_sel),
    .two_wire(two_wire), .func(func), .low_batt(low_batt), .rpt(rpt),
    .slot(slot), .learn_ok(learn_ok), .overwrite(overwrite),
    .data_o(data_o), .clk_o(clk_o), .busy(busy)
  );

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // one frame; scramble changes inputs after accept, poke requests mid-frame
  task automatic run_frame(input logic two, input logic st, input logic [3:0] f,
                           input logic lb, input logic rp, input logic [1:0] sl,
                           input logic ok, input logic ow,
                           input bit scramble, input bit poke);
    logic [9:0] exp_bits, got;
    int upb, len, bad_wave, bad_busy, idle_bad;
    upb = two ? 2 : 3;
    len = NBITS * upb * UNIT;
    exp_bits = st ? {1'b1, 4'b0000, ok, ow, sl, 1'b0}
                  : {1'b1, f, lb, rp, sl, 1'b0};
    @(negedge clk);
    two_wire = two; status_sel = st; func = f; low_batt = lb; rpt = rp;
    slot = sl; learn_ok = ok; overwrite = ow; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (scramble) begin
      two_wire = ~two; status_sel = ~st; func = ~f; low_batt = ~lb;
      rpt = ~rp; slot = ~sl; learn_ok = ~ok; overwrite = ~ow;
    end
    for (int k = 0; k <= len; k++) begin
      d_s[k] = data_o; c_s[k] = clk_o; b_s[k] = busy;
      if (poke && k == len / 2) begin
        req = 1'b1; status_sel = ~st; func = ~f; slot = ~sl; two_wire = ~two;
      end
      if (poke && k == len / 2 + 2) req = 1'b0;
      if (k < len) @(negedge clk);
    end
    bad_wave = 0; bad_busy = 0;
    for (int k = 0; k < len; k++) begin
      int i, u;
      logic b, ed, ec;
      i = k / (upb * UNIT);
      u = (k % (upb * UNIT)) / UNIT;
      b = exp_bits[9 - i];
      ed = two ? b : ((u == 0) || (u == 1 && !b));
      ec = two && (u == 0);
      if (d_s[k] !== ed || c_s[k] !== ec) bad_wave++;
      if (b_s[k] !== 1'b1) bad_busy++;
    end
    for (int i = 0; i < NBITS; i++) begin
      logic s;
      s = d_s[i * upb * UNIT + UNIT];
      got[9 - i] = two ? s : ~s;
    end
    if (st) check(got === exp_bits, "R3 status frame bits", got, exp_bits);
    else    check(got === exp_bits, "R2 event frame bits", got, exp_bits);
    check(got[9] === 1'b1 && got[0] === 1'b0, "R4 start/stop bits", {got[9], got[0]}, 2'b10);
    if (two) check(bad_wave == 0, "R6 two-wire waveform mismatches", bad_wave, 0);
    else     check(bad_wave == 0, "R5 one-wire waveform mismatches", bad_wave, 0);
    check(bad_busy == 0 && b_s[len] === 1'b0, "R7 busy length", bad_busy, 0);
    check(b_s[len] === 1'b0 && d_s[len] === 1'b0 && c_s[len] === 1'b0,
          "R1 idle after frame", {b_s[len], d_s[len], c_s[len]}, 0);
    if (scramble)
      check(got === exp_bits && bad_wave == 0, "R9 captured fields", got, exp_bits);
    if (poke) begin
      idle_bad = 0;
      for (int k = 0; k < 2 * MAXL; k++) begin
        @(negedge clk);
        if (busy !== 1'b0 || data_o !== 1'b0 || clk_o !== 1'b0) idle_bad++;
      end
      check(idle_bad == 0 && bad_wave == 0, "R8 mid-frame request ignored", idle_bad, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && data_o === 1'b0 && clk_o === 1'b0,
          "R1 reset state", {busy, data_o, clk_o}, 0);
  endtask

  task automatic t_event_one_wire();
    run_frame(1'b0, 1'b0, 4'b1010, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 0, 0);
    run_frame(1'b0, 1'b0, 4'b1111, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 0, 0);
    run_frame(1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic t_event_two_wire();
    run_frame(1'b1, 1'b0, 4'b0110, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 0, 0);
    run_frame(1'b1, 1'b0, 4'b1001, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 0, 0);
  endtask

  task automatic t_status();
    run_frame(1'b0, 1'b1, 4'b1111, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 0, 0);
    run_frame(1'b1, 1'b1, 4'b1111, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 0, 0);
  endtask

  task automatic t_capture();
    run_frame(1'b0, 1'b0, 4'b1100, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1, 0);
    run_frame(1'b1, 1'b1, 4'b0011, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 1, 0);
  endtask

  task automatic t_ignore();
    run_frame(1'b1, 1'b0, 4'b0101, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 0, 1);
    run_frame(1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; status_sel = 1'b0; two_wire = 1'b0;
    func = '0; low_batt = 1'b0; rpt = 1'b0; slot = '0;
    learn_ok = 1'b0; overwrite = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_event_one_wire();
    t_event_two_wire();
    t_status();
    t_capture();
    t_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule